// File: doc/BRIEF.md
# Two-Level Page Table Walker

On a translation miss this block walks a two-level translation tree held in memory. It forms the address of a directory entry from a root base value and the top bits of the virtual address, reads that entry, and then reads the leaf entry from the table that the directory entry points to. Each of these reads goes through one memory port that handles a single request at a time. If either entry has its present bit clear, the walk ends with a not-present fault. The fault reports the virtual address and the level that failed.

A successful walk marks the leaf entry as accessed, and also as dirty when the access that missed was a write. If this changes the entry, the walker writes the changed entry back to memory. It then presents the virtual page number and the updated leaf entry for one cycle so that the TLB can be refilled. Loading pages from backing store is not part of this block.

The virtual address has three fields:

- bits 31:22 index the directory;
- bits 21:12 index the table;
- bits 11:0 are the page offset.

Entries are 4 bytes wide and have these fields:

- bit 0: present
- bit 1: writable
- bit 2: user
- bit 5: accessed
- bit 6: dirty
- bits 31:12: frame base

Top module: `tlb_refill_walker`

## Requirements
- R1: After reset, and whenever the walker is idle, `busy`, `mem_req`, `refill_valid` and `fault_valid` are all 0.
- R2: A walk starts when `miss_valid` is high while the walker is idle. Its first memory access is a read (`mem_we`=0) at address {`root_base`[31:12], `miss_vaddr`[31:22], 2'b00`}. The low 12 bits of `root_base` have no effect.
- R3: If the directory entry has bit 0 clear, the walk ends with `fault_valid`, `fault_level`=0 and `fault_vaddr` equal to the missing address. No further memory access is made, whatever bits 31:1 of that entry hold.
- R4: If the directory entry has bit 0 set, the second access is a read at {dir[31:12], vaddr[21:12], 2'b00}.
- R5: If the leaf entry has bit 0 clear, the walk ends with `fault_level`=1 and `fault_vaddr` equal to the missing address, with no write, whatever bits 31:1 hold.
- R6: On success, `refill_vpn` is vaddr[31:12] and `refill_pte` is the leaf entry with bit 5 set, and bit 6 also set on a write miss. A fault and a refill are never presented together.
- R7: When that update changes the leaf entry, exactly one write (`mem_we`=1) of the updated entry is made to the leaf address before the refill.
- R8: When the leaf entry already has bit 5 set, and bit 6 set on a write miss, no write is made.
- R9: `refill_valid` or `fault_valid` is high for exactly one cycle, the cycle after the edge that accepts the walk's last memory access.
- R10: `miss_valid` is ignored while `busy` is high. Such a request changes neither the result nor the memory accesses.
- R11: A request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until the edge at which `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | TLB miss request |
| miss_vaddr | input | 32 | Virtual address that missed |
| miss_write | input | 1 | Miss came from a write access |
| root_base | input | 32 | Directory base register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted or completed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Walk in progress |
| refill_valid | output | 1 | Refill entry valid |
| refill_vpn | output | 20 | Virtual page number |
| refill_pte | output | 32 | Updated leaf entry |
| fault_valid | output | 1 | Not-present fault |
| fault_vaddr | output | 32 | Faulting virtual address |
| fault_level | output | 1 | 0 for directory, 1 for table |

## Verification
Each walk result is due one cycle after the clock edge that accepts the walk's final memory access with `mem_ack`. That final access is the directory read, the leaf read or the write-back, depending on the case. The memory model in the bench records the cycle in which it presented each acknowledge, and the bench samples outputs at falling edges. Every check compares the cycle in which the result is seen against the recorded acknowledge cycle plus one, and confirms that the result is gone one cycle later. The bench checks the effect of a second miss, injected while the walker is busy, only after the walk ends and a few idle cycles have passed. At that point it compares the access counts with the expected ones.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W   = 32;
  localparam int OFF_W    = 12;
  localparam int IDX_W    = 10;
  localparam int LEVELS   = 2;
  localparam int ENT_LG   = 2;
  localparam int FRAME_W  = ADDR_W - OFF_W;
  localparam int BIT_PRES = 0;
  localparam int BIT_ACC  = 5;
  localparam int BIT_DIRTY = 6;
  localparam logic [ADDR_W-1:0] FRAME_MASK = {{FRAME_W{1'b1}}, {OFF_W{1'b0}}};

  typedef enum logic [2:0] {
    WK_IDLE, WK_RD_DIR, WK_RD_LEAF, WK_WB, WK_DONE, WK_FAULT
  } walk_state_t;

  // index field of a virtual address for a given tree level
  function automatic logic [IDX_W-1:0] level_index(input logic [ADDR_W-1:0] va, input int lvl);
    logic [ADDR_W-1:0] sh;
    sh = va >> (ADDR_W - (lvl + 1) * IDX_W);
    return sh[IDX_W-1:0];
  endfunction

  // frame of the pointing value combined with a scaled index
  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] src,
                                                   input logic [IDX_W-1:0] idx);
    return (src & FRAME_MASK) | (ADDR_W'(idx) << ENT_LG);
  endfunction

  // leaf entry after setting accessed, and dirty for writes
  function automatic logic [ADDR_W-1:0] mark_leaf(input logic [ADDR_W-1:0] ent, input logic wr);
    logic [ADDR_W-1:0] r;
    r = ent;
    r[BIT_ACC] = 1'b1;
    if (wr) r[BIT_DIRTY] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] src,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  assign addr = entry_addr(src, idx);
endmodule

// File: rtl/ptw_leaf_update.sv
module ptw_leaf_update
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] entry,
  input  logic              is_write,
  output logic [ADDR_W-1:0] updated,
  output logic              need_wb
);
  assign updated = mark_leaf(entry, is_write);
  assign need_wb = (updated != entry);
endmodule

// File: rtl/tlb_refill_walker.sv
module tlb_refill_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [31:0]       miss_vaddr,
  input  logic              miss_write,
  input  logic [31:0]       root_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              refill_valid,
  output logic [19:0]       refill_vpn,
  output logic [31:0]       refill_pte,
  output logic              fault_valid,
  output logic [31:0]       fault_vaddr,
  output logic              fault_level
);
  walk_state_t       state;
  logic [ADDR_W-1:0] va_q, addr_q, leaf_q;
  logic              wr_q, lvl_q;

  // named internal events
  logic              acc_done;
  logic              ent_present;
  logic              walk_start;
  logic              walk_is_write;
  logic [ADDR_W-1:0] lvl_addr [LEVELS];
  logic [ADDR_W-1:0] leaf_upd;
  logic              leaf_need_wb;

  assign acc_done      = mem_req & mem_ack;
  assign ent_present   = mem_rdata[BIT_PRES];
  assign walk_start    = (state == WK_IDLE) & miss_valid;
  assign walk_is_write = wr_q;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    if (l == 0) begin : g_root
      ptw_entry_addr u_addr (
        .src  (root_base),
        .idx  (level_index(miss_vaddr, l)),
        .addr (lvl_addr[l])
      );
    end else begin : g_next
      ptw_entry_addr u_addr (
        .src  (mem_rdata),
        .idx  (level_index(va_q, l)),
        .addr (lvl_addr[l])
      );
    end
  end

  ptw_leaf_update u_leaf (
    .entry    (mem_rdata),
    .is_write (wr_q),
    .updated  (leaf_upd),
    .need_wb  (leaf_need_wb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= WK_IDLE;
      va_q   <= '0;
      addr_q <= '0;
      leaf_q <= '0;
      wr_q   <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      unique case (state)
        WK_IDLE: if (walk_start) begin
          va_q   <= miss_vaddr;
          wr_q   <= miss_write;
          addr_q <= lvl_addr[0];
          state  <= WK_RD_DIR;
        end
        WK_RD_DIR: if (acc_done) begin
          if (!ent_present) begin
            lvl_q <= 1'b0;
            state <= WK_FAULT;
          end else begin
            addr_q <= lvl_addr[1];
            state  <= WK_RD_LEAF;
          end
        end
        WK_RD_LEAF: if (acc_done) begin
          if (!ent_present) begin
            lvl_q <= 1'b1;
            state <= WK_FAULT;
          end else begin
            leaf_q <= leaf_upd;
            state  <= leaf_need_wb ? WK_WB : WK_DONE;
          end
        end
        WK_WB:    if (acc_done) state <= WK_DONE;
        WK_DONE:  state <= WK_IDLE;
        WK_FAULT: state <= WK_IDLE;
        default:  state <= WK_IDLE;
      endcase
    end
  end

  assign mem_req      = (state == WK_RD_DIR) | (state == WK_RD_LEAF) | (state == WK_WB);
  assign mem_we       = (state == WK_WB);
  assign mem_addr     = addr_q;
  assign mem_wdata    = leaf_q;
  assign busy         = (state != WK_IDLE);
  assign refill_valid = (state == WK_DONE);
  assign refill_vpn   = va_q[ADDR_W-1:OFF_W];
  assign refill_pte   = leaf_q;
  assign fault_valid  = (state == WK_FAULT);
  assign fault_vaddr  = va_q;
  assign fault_level  = lvl_q;
endmodule

// File: rtl/ptw_checks.sv
module ptw_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        wb_acc,
  input logic        wb_dirty,
  input logic        wb_pres,
  input logic        walk_is_write,
  input logic        refill_valid,
  input logic        leaf_acc,
  input logic        leaf_pres,
  input logic        fault_valid
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !refill_valid && !fault_valid));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_no_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(refill_valid && fault_valid));

  p_refill_marked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |-> (leaf_acc && leaf_pres));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid || fault_valid) |=> !(refill_valid || fault_valid));

  p_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid || fault_valid) |-> $past(mem_req && mem_ack));

  p_wb_accessed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (wb_acc && wb_pres));

  p_wb_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && walk_is_write) |-> wb_dirty);
endmodule

bind tlb_refill_walker ptw_checks u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .mem_req       (mem_req),
  .mem_ack       (mem_ack),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .wb_acc        (mem_wdata[5]),
  .wb_dirty      (mem_wdata[6]),
  .wb_pres       (mem_wdata[0]),
  .walk_is_write (walk_is_write),
  .refill_valid  (refill_valid),
  .leaf_acc      (refill_pte[5]),
  .leaf_pres     (refill_pte[0]),
  .fault_valid   (fault_valid)
);

// File: tb/tlb_refill_walker_test.sv
module tlb_refill_walker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_vaddr = '0;
  logic        miss_write = 1'b0;
  logic [31:0] root_base = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        busy, refill_valid, fault_valid, fault_level;
  logic [19:0] refill_vpn;
  logic [31:0] refill_pte, fault_vaddr;

  int pass_cnt = 0, total_cnt = 0, cyc = 0;

  tlb_refill_walker uut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .miss_write(miss_write), .root_base(root_base), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_pte(refill_pte),
    .fault_valid(fault_valid), .fault_vaddr(fault_vaddr), .fault_level(fault_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model
  logic [31:0] mem [logic [31:0]];
  int          rd_cnt, wr_cnt, ack_cyc, lat, hold_err;
  logic [31:0] rd_log [4];
  logic [31:0] wr_addr, wr_data, seen_addr;
  logic        seen;

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      seen = 1'b0;
    end else if (mem_req) begin
      if (!seen) begin
        seen = 1'b1;
        seen_addr = mem_addr;
        lat = $urandom_range(0, 2);
      end
      if (mem_addr != seen_addr) hold_err++;
      if (lat == 0) begin
        mem_ack = 1'b1;
        ack_cyc = cyc;
        if (mem_we) begin
          wr_cnt++;
          wr_addr = mem_addr;
          wr_data = mem_wdata;
          mem[mem_addr] = mem_wdata;
        end else begin
          if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
          rd_cnt++;
          mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        end
      end else lat--;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total_cnt++;
    if (ok) pass_cnt++;
    else $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
  endtask

  function automatic logic [31:0] f_dir_addr(input logic [31:0] rb, input logic [31:0] va);
    return {rb[31:12], va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] f_leaf_addr(input logic [31:0] de, input logic [31:0] va);
    return {de[31:12], va[21:12], 2'b00};
  endfunction
  function automatic logic [31:0] f_marked(input logic [31:0] pe, input logic wr);
    return pe | 32'h20 | (wr ? 32'h40 : 32'h0);
  endfunction

  task automatic run_walk(input logic [31:0] rb, input logic [31:0] va, input logic wr,
                          input logic [31:0] dent, input logic [31:0] pent);
    logic [31:0] da, la, nw;
    bit got, gr, gf, gl;
    int rcyc, rd_at_end;
    logic [31:0] gvpn, gpte, gfva;
    da = f_dir_addr(rb, va);
    la = f_leaf_addr(dent, va);
    nw = f_marked(pent, wr);
    mem.delete();
    mem[da] = dent;
    if (la != da) mem[la] = pent;
    rd_cnt = 0; wr_cnt = 0; hold_err = 0; seen = 1'b0;
    got = 0; gr = 0; gf = 0; gl = 0; rcyc = 0; gvpn = '0; gpte = '0; gfva = '0;
    @(negedge clk);
    root_base = rb; miss_vaddr = va; miss_write = wr; miss_valid = 1'b1;
    for (int i = 0; i < 300 && !got; i++) begin
      @(negedge clk);
      miss_valid = (i == 0);   // second miss while busy must be ignored (R10)
      miss_vaddr = ~va;
      miss_write = ~wr;
      if (refill_valid || fault_valid) begin
        got = 1; gr = refill_valid; gf = fault_valid; gl = fault_level;
        gvpn = {12'h0, refill_vpn}; gpte = refill_pte; gfva = fault_vaddr; rcyc = cyc;
      end
    end
    miss_valid = 1'b0;
    if (!got) begin
      check(0, "R9", "watchdog: no result", 0, 1);
      return;
    end
    check(rcyc == ack_cyc + 1, "R9", "result cycle", rcyc, ack_cyc + 1);
    @(negedge clk);
    check(!refill_valid && !fault_valid, "R9", "single-cycle result",
          {refill_valid, fault_valid}, 0);
    rd_at_end = rd_cnt;
    check(rd_log[0] == da, "R2", "directory read address", rd_log[0], da);
    check(hold_err == 0, "R11", "request held until ack", hold_err, 0);
    if (!dent[0]) begin
      check(gf && !gr && gl == 1'b0, "R3", "directory fault level 0", {gr, gf, gl}, 3'b010);
      check(gfva == va, "R3", "fault vaddr", gfva, va);
      check(rd_cnt == 1 && wr_cnt == 0, "R3", "no access after directory fault",
            rd_cnt * 16 + wr_cnt, 16);
    end else begin
      check(rd_log[1] == la, "R4", "leaf read address", rd_log[1], la);
      if (!pent[0]) begin
        check(gf && !gr && gl == 1'b1, "R5", "leaf fault level 1", {gr, gf, gl}, 3'b011);
        check(gfva == va, "R5", "fault vaddr", gfva, va);
        check(wr_cnt == 0, "R5", "no write after leaf fault", wr_cnt, 0);
      end else begin
        check(gr && !gf, "R6", "refill presented", {gr, gf}, 2'b10);
        check(gvpn == {12'h0, va[31:12]}, "R6", "refill vpn", gvpn, {12'h0, va[31:12]});
        check(gpte == nw, "R6", "refill entry", gpte, nw);
        if (nw != pent) begin
          check(wr_cnt == 1 && wr_addr == la, "R7", "write-back address", wr_addr, la);
          check(wr_data == nw, "R7", "write-back data", wr_data, nw);
        end else begin
          check(wr_cnt == 0, "R8", "no write when flags already set", wr_cnt, 0);
        end
      end
    end
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && rd_cnt == rd_at_end, "R10", "miss during walk ignored",
          {busy, mem_req}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "R9", "global watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", pass_cnt, total_cnt);
    $finish;
  end

  initial begin
    logic [31:0] rb, va, de, pe;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && !refill_valid && !fault_valid, "R1", "reset outputs quiet",
          {busy, mem_req, refill_valid, fault_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !mem_req, "R1", "idle after reset", {busy, mem_req}, 0);

    // directed corners
    run_walk(32'h0010_0ABC, 32'h1234_5678, 1'b0, 32'hFFFF_FFFE, 32'h0);          // R3 garbage bits
    run_walk(32'h0010_0000, 32'hFFC0_1000, 1'b1, 32'h0020_0001, 32'hFFFF_FFFE);  // R5 garbage bits
    run_walk(32'h0010_0000, 32'h0040_2000, 1'b0, 32'h0020_0007, 32'h0030_0023);  // R8 accessed set
    run_walk(32'h0010_0000, 32'h0040_2000, 1'b1, 32'h0020_0007, 32'h0030_0023);  // R7 dirty needed
    run_walk(32'h0010_0000, 32'h0040_2000, 1'b1, 32'h0020_0007, 32'h0030_0063);  // R8 both set
    run_walk(32'h0010_0000, 32'h0040_2000, 1'b0, 32'h0020_0001, 32'h0030_0001);  // R7 accessed only

    // constrained random walks
    for (int t = 0; t < 60; t++) begin
      rb = $urandom();
      rb[31:12] = 20'h00100 + 20'($urandom_range(0, 255));
      va = $urandom();
      de = $urandom();
      de[31:12] = 20'h00400 + 20'($urandom_range(0, 255));
      de[0] = ($urandom_range(0, 4) != 0);
      pe = $urandom();
      pe[0] = ($urandom_range(0, 4) != 0);
      run_walk(rb, va, 1'($urandom_range(0, 1)), de, pe);
    end

    $display("%0d/%0d checks passed", pass_cnt, total_cnt);
    $finish;
  end
endmodule